// File: doc/BRIEF.md
# Colour Correction Matrix with Cross-Product Term

Three photodiode channels each deliver an unsigned 14-bit reading. This block maps those readings to approximate tristimulus values. It forms a four-element input row vector and multiplies it by a programmable 4 × 3 matrix of signed coefficients, which gives three signed outputs. The first three elements of the vector are the channel readings. The fourth is a nonlinear term: the product of channels A and B, scaled back down to 14 bits. The extra row lets a trained matrix correct some of the curvature that a purely linear 3 × 3 map leaves behind.

Software loads the coefficients one at a time through a write port. Each write carries an address and an 18-bit value. Sample triples enter with a valid strobe, and the block accepts a new triple on every clock. Each result triple leaves a fixed three cycles later with its own strobe. The block holds two copies of the coefficients. Writes land in a staging copy. The arithmetic copy is refreshed only when a triple is accepted, so every output triple is computed from one consistent matrix.

Top module: `colour_matrix`

## Requirements
- R1: After reset, out_valid is low and all three outputs are zero. The coefficient matrix holds 1.0 (raw value 65536) at addresses 0, 4 and 8 and zero everywhere else, so a triple passes through unchanged.
- R2: The input vector is v0 = in_a, v1 = in_b, v2 = in_c, all unsigned. v3 is bits 27..14 of the 28-bit unsigned product in_a × in_b.
- R3: Output column j is the sum over i of v_i × M[i][j]. Coefficient M[i][j] is written at address 3·i + j. Rows 0..3 are v0..v3, and columns 0, 1 and 2 drive out_x, out_y and out_z.
- R4: Coefficients are signed two's complement with 16 fractional bits. Each output is the exact sum with the fractional bits rounded away as floor((sum + 2^15) / 2^16), so ties round toward plus infinity. The result is limited to the signed 24-bit range.
- R5: out_valid equals in_valid from exactly three cycles earlier. Back-to-back triples are accepted with no stall or gap.
- R6: A coefficient write presented in cycle w is used by every triple presented after cycle w. It is not used by any triple presented in cycle w or earlier, including triples still in flight.
- R7: A write to address 12, 13, 14 or 15 has no effect on any coefficient.
- R8: An all-zero input triple produces an all-zero output triple, whatever the coefficients hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient address, 3·row + column |
| cfg_data | input | 18 | Signed coefficient, 16 fractional bits |
| in_valid | input | 1 | Input triple valid |
| in_a | input | 14 | Channel A reading, unsigned |
| in_b | input | 14 | Channel B reading, unsigned |
| in_c | input | 14 | Channel C reading, unsigned |
| out_valid | output | 1 | Output triple valid |
| out_x | output | 24 | Output column 0, signed |
| out_y | output | 24 | Output column 1, signed |
| out_z | output | 24 | Output column 2, signed |

## Verification
The assertions check the following on every cycle:
- the three-cycle valid delay;
- that a legal write lands in the staging copy and an out-of-range write leaves it untouched;
- that the arithmetic copy moves only on an accepted triple, and then to the staging contents;
- that a zero input triple gives a zero output.

Some behaviour appears only in the bench's scenarios, where a behavioural model predicts each output triple:
- the numeric result of the matrix product, including the scaling of the cross term;
- rounding ties in both signs;
- extreme coefficient and input values;
- the exact cycle at which a write made alongside a stream of triples starts to change the results.

// File: rtl/colour_matrix.sv
module colour_matrix #(
  parameter int IN_W  = 14,
  parameter int CW    = 18,
  parameter int FRAC  = 16,
  parameter int OUT_W = 24,
  localparam int AW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [CW-1:0]           cfg_data,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_a,
  input  logic [IN_W-1:0]         in_b,
  input  logic [IN_W-1:0]         in_c,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_x,
  output logic signed [OUT_W-1:0] out_y,
  output logic signed [OUT_W-1:0] out_z
);
  localparam int NR = 4;
  localparam int NC = 3;
  localparam int NK = NR * NC;
  localparam int PW = IN_W + 1 + CW;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] HALF = SW'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [SW-1:0] OMAX = SW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] OMIN = -OMAX - SW'(1);

  function automatic logic [NK-1:0][CW-1:0] ident_bank();
    logic [NK-1:0][CW-1:0] b;
    b = '0;
    for (int r = 0; r < NC; r++) b[r*NC+r] = CW'(64'd1 << FRAC);
    return b;
  endfunction

  logic [NK-1:0][CW-1:0]   live_q, act_q;
  logic [2*IN_W-1:0]       ab;
  logic [NR-1:0][IN_W-1:0] s1_x;
  logic                    s1_v, s2_v, s3_v;
  logic signed [PW-1:0]    p_q [NK];

  assign ab = {{IN_W{1'b0}}, in_a} * {{IN_W{1'b0}}, in_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= ident_bank();
    else if (cfg_we && cfg_addr < AW'(NK)) live_q[cfg_addr] <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_x  <= '0;
      act_q <= ident_bank();
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_x  <= {ab[2*IN_W-1:IN_W], in_c, in_b, in_a};
        act_q <= live_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
      for (int k = 0; k < NK; k++) p_q[k] <= '0;
    end else begin
      s2_v <= s1_v;
      for (int k = 0; k < NK; k++)
        p_q[k] <= PW'($signed({1'b0, s1_x[k/NC]})) * PW'($signed(act_q[k]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s3_v <= 1'b0;
    else        s3_v <= s2_v;
  end

  for (genvar c = 0; c < NC; c++) begin : g_col
    logic signed [SW-1:0]    acc, rsh, sat;
    logic signed [OUT_W-1:0] res_q;

    always_comb begin
      acc = '0;
      for (int r = 0; r < NR; r++) acc = acc + SW'(p_q[r*NC+c]);
    end

    assign rsh = (acc + HALF) >>> FRAC;
    assign sat = (rsh > OMAX) ? OMAX : (rsh < OMIN) ? OMIN : rsh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= sat[OUT_W-1:0];
    end
  end

  assign out_valid = s3_v;
  assign out_x     = g_col[0].res_q;
  assign out_y     = g_col[1].res_q;
  assign out_z     = g_col[2].res_q;
endmodule

// File: rtl/colour_matrix_chk.sv
module colour_matrix_chk #(
  parameter int IN_W  = 14,
  parameter int CW    = 18,
  parameter int OUT_W = 24,
  parameter int AW    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [AW-1:0]           cfg_addr,
  input logic [CW-1:0]           cfg_data,
  input logic                    in_valid,
  input logic [IN_W-1:0]         in_a,
  input logic [IN_W-1:0]         in_b,
  input logic [IN_W-1:0]         in_c,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_x,
  input logic signed [OUT_W-1:0] out_y,
  input logic signed [OUT_W-1:0] out_z,
  input logic [11:0][CW-1:0]     live_q,
  input logic [11:0][CW-1:0]     act_q
);
  logic [1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  // R5
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr < AW'(12)) |=> (live_q[$past(cfg_addr)] == $past(cfg_data)));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr >= AW'(12)) |=> $stable(live_q));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(act_q));

  // R6
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (act_q == $past(live_q)));

  // R8
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((since == 2'd3) && $past(in_valid && in_a == '0 && in_b == '0 && in_c == '0, 3))
      |-> (out_x == '0 && out_y == '0 && out_z == '0));
endmodule

bind colour_matrix colour_matrix_chk #(.IN_W(IN_W), .CW(CW), .OUT_W(OUT_W), .AW(AW)) u_chk (.*);

// File: tb/colour_matrix_bench.sv
`timescale 1ns/1ps
module colour_matrix_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_we, in_valid, out_valid;
  logic [3:0] cfg_addr;
  logic [17:0] cfg_data;
  logic [13:0] in_a, in_b, in_c;
  logic signed [23:0] out_x, out_y, out_z;

  colour_matrix u_colour_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z));

  typedef struct { int due; longint x; longint y; longint z; } exp_t;
  exp_t q[$];
  longint mdl[12];
  int checks = 0, failures = 0, cyc = 0;
  int seed = 7;
  string tag = "R1";
  bit done = 0;

  function automatic longint round_sat(longint s);
    longint r = (s + 64'sd32768) >>> 16;
    if (r > 64'sd8388607) r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r;
  endfunction

  task automatic check(string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic int rnd14();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 9) & 16383;
  endfunction

  task automatic step(bit v, int a = 0, int b = 0, int c = 0,
                      bit we = 0, int addr = 0, longint data = 0);
    longint vv[4];
    longint s[3];
    exp_t e;
    @(negedge clk);
    if (q.size() > 0 && q[0].due == cyc) begin
      check("R5 out_valid", longint'(out_valid), 1);
      check("out_x", longint'(out_x), q[0].x);
      check("out_y", longint'(out_y), q[0].y);
      check("out_z", longint'(out_z), q[0].z);
      void'(q.pop_front());
    end else begin
      check("R5 idle out_valid", longint'(out_valid), 0);
    end
    in_valid = v; in_a = 14'(a); in_b = 14'(b); in_c = 14'(c);
    cfg_we = we; cfg_addr = 4'(addr); cfg_data = 18'(data);
    if (v) begin
      vv[0] = a; vv[1] = b; vv[2] = c;
      vv[3] = (longint'(a) * longint'(b)) >> 14;
      for (int j = 0; j < 3; j++) begin
        s[j] = 0;
        for (int i = 0; i < 4; i++) s[j] += vv[i] * mdl[3*i+j];
      end
      e.due = cyc + 3; e.x = round_sat(s[0]); e.y = round_sat(s[1]); e.z = round_sat(s[2]);
      q.push_back(e);
    end
    if (we && addr < 12) mdl[addr] = data;
    @(posedge clk);
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0);
  endtask

  task automatic wr(int addr, longint data);
    step(0, 0, 0, 0, 1, addr, data);
  endtask

  task automatic clear_bank();
    for (int k = 0; k < 12; k++) wr(k, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_data = 0;
    in_valid = 0; in_a = 0; in_b = 0; in_c = 0;
    for (int k = 0; k < 12; k++) mdl[k] = (k == 0 || k == 4 || k == 8) ? 65536 : 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("reset out_valid", longint'(out_valid), 0);
    check("reset out_x", longint'(out_x), 0);
    check("reset out_y", longint'(out_y), 0);
    check("reset out_z", longint'(out_z), 0);
    rst_n = 1;

    // R1: identity pass-through from reset coefficients
    tag = "R1";
    step(1, 100, 200, 300);
    step(1, 16383, 0, 1);
    step(1, 0, 16383, 5);
    drain();

    // R3: full signed matrix, back-to-back random triples
    tag = "R3";
    for (int k = 0; k < 12; k++) wr(k, longint'((k * 39119 + 5003) % 200000) - 100000);
    for (int n = 0; n < 24; n++) step(1, rnd14(), rnd14(), rnd14());
    drain();

    // R2: cross-product row alone
    tag = "R2";
    clear_bank();
    wr(9, 65536); wr(10, -65536); wr(11, 32768);
    step(1, 16383, 16383, 0);
    step(1, 128, 128, 7);
    step(1, 127, 129, 7);
    step(1, 16383, 1, 0);
    step(1, 9000, 12000, 100);
    drain();

    // R4: rounding ties in both signs
    tag = "R4";
    clear_bank();
    wr(0, 32768); wr(1, -32768); wr(2, 1);
    step(1, 1, 0, 0);
    step(1, 3, 0, 0);
    step(1, 5, 0, 0);
    step(1, 16383, 0, 0);
    drain();

    // R4: extreme coefficients with maximum inputs
    tag = "R4";
    for (int k = 0; k < 12; k++) wr(k, (k % 3 == 0) ? 131071 : ((k % 3 == 1) ? -131072 : 1));
    step(1, 16383, 16383, 16383);
    step(1, 16383, 16383, 0);
    drain();

    // R6: writes alongside a stream of triples
    tag = "R6";
    for (int n = 0; n < 10; n++) step(1, 1000 + n, 2000, 3000, 1, n % 12, 70000 - 9000 * n);
    step(1, 500, 600, 700, 1, 0, -50000);
    step(1, 500, 600, 700);
    drain();

    // R7: out-of-range addresses ignored
    tag = "R7";
    for (int a = 12; a < 16; a++) wr(a, 131071);
    for (int n = 0; n < 4; n++) step(1, rnd14(), rnd14(), rnd14(), 1, 12 + n, -131072);
    drain();

    // R5: valid with gaps
    tag = "R5";
    step(1, 11, 22, 33); step(0); step(0); step(1, 44, 55, 66);
    step(1, 77, 88, 99); step(0); step(1, 5, 5, 5); step(0); step(0);
    drain();

    // R8: zero input gives zero output
    tag = "R8";
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule